// File: doc/BRIEF.md
# Program-Counter Stride Prefetch Table

This block watches the stream of demand load accesses, each tagged with the program counter of the load instruction and the cache-line address it touched. It keeps a small set-associative table keyed by that program counter. Each entry remembers the last line address seen for that instruction, the distance between its last two accesses (the stride), and a saturating confidence count. When an instruction walks memory with a steady, nonzero stride, its confidence climbs. Once confidence reaches the threshold, each further access from that instruction produces a burst of predicted byte addresses, one per handshake, on a valid/ready output stream.

The number of addresses in a burst comes from the `degree` input, sampled when the triggering access is accepted. Predictions that would leave the 4 KiB-style page of the triggering access are skipped. While a burst is in flight the block holds `acc_ready` low, so the access port and the output stream never overlap. Table sets are picked by an XOR fold of the program counter. A miss claims an empty way, or the least recently used way when the set is full.

Top module: `stride_pf`

## Requirements
- R1: The set index is `((pc >> 1) ^ ((pc >> 1) >> TAG_SHIFT))` truncated to log2(SETS) bits. The full PC is stored as the tag, so two PCs that share a set but differ in any bit occupy separate entries.
- R2: On a hit, the observed stride is the incoming line address minus the stored last line address, modulo 2^LINE_W. The stored last line address becomes the incoming line address.
- R3: If the observed stride equals the stored stride and is nonzero, confidence rises by one, saturating at CONF_MAX.
- R4: If the observed stride differs from the stored stride, or is zero, then: at confidence zero the stored stride is replaced by the observed stride; otherwise confidence falls by one and the stored stride is kept.
- R5: An access whose updated confidence is below CONF_MAX, and any table miss, issues no prefetch.
- R6: An access whose updated confidence equals CONF_MAX issues candidates for d = 1 .. `degree` in increasing d. Candidate d has byte address `(line + stride*d) << BLK_SHIFT` (line arithmetic modulo 2^LINE_W), where stride is the observed stride. Each emitted candidate is presented on `pf_addr` with `pf_valid` high and is consumed when `pf_ready` is high at a clock edge.
- R7: A candidate whose line address bits [LINE_W-1 : PAGE_SHIFT-BLK_SHIFT] differ from those of the triggering line is dropped. It spends one cycle with `pf_valid` low, and the remaining candidates are still evaluated.
- R8: On a miss, the first invalid way of the set is chosen, or otherwise the least recently used way. The new entry holds the PC as tag, the line as last address, stride zero and confidence zero. Both hits and allocations make the touched way the most recently used.
- R9: `acc_ready` is low from the cycle after a prefetching access is accepted until the last candidate has been consumed or dropped. For a burst of degree D with S stalled cycles, that is D+S cycles. `degree` = 0 issues nothing and leaves `acc_ready` high.
- R10: After reset all entries are invalid, `acc_ready` is high and `pf_valid` is low.
- R11: While `pf_valid` is high and `pf_ready` is low, `pf_valid` stays high and `pf_addr` holds its value on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | A demand access is offered |
| acc_ready | output | 1 | Block can take an access (no burst in flight) |
| acc_pc | input | PC_W | Program counter of the load |
| acc_line | input | LINE_W | Line address of the access |
| degree | input | DEG_W | Number of candidates per burst, sampled on acceptance |
| pf_valid | output | 1 | A prefetch byte address is offered |
| pf_ready | input | 1 | Consumer takes the offered address |
| pf_addr | output | LINE_W+BLK_SHIFT | Prefetch byte address |

## Verification
The bench drives a reference model of the table written from the requirements and compares every burst, address by address. Steady strides of several sizes and signs (including zero) are trained per PC under all degrees from 0 to 5. These runs separate correct saturation and threshold timing from early or late bursts, and separate correct page dropping (large strides) from in-page emission. Dedicated patterns break a trained stride to exercise the confidence decay and stride replacement, and fill a set beyond its ways to expose a wrong victim choice. They also use two PCs that collide in the hash, to show the full tag is compared. A long pseudo-random mix of PCs with noisy strides and a stalling consumer then checks the hold behaviour and the busy window length together.

// File: rtl/stride_pf_pkg.sv
package stride_pf_pkg;

    typedef enum logic {
        PF_IDLE = 1'b0,
        PF_RUN  = 1'b1
    } pf_state_e;

    // Saturating confidence step: up on a confirmed stride, down otherwise.
    function automatic int unsigned conf_next(input int unsigned cur,
                                              input logic        confirmed,
                                              input int unsigned cap);
        if (confirmed)
            return (cur < cap) ? cur + 1 : cur;
        return (cur == 0) ? 0 : cur - 1;
    endfunction

endpackage

// File: rtl/stride_pf_hash.sv
module stride_pf_hash #(
    parameter int PC_W      = 16,
    parameter int SET_W     = 2,
    parameter int TAG_SHIFT = 4
) (
    input  logic [PC_W-1:0]  pc,
    output logic [SET_W-1:0] set_idx
);
    logic [PC_W-1:0] half;
    logic [PC_W-1:0] folded;

    assign half    = pc >> 1;
    assign folded  = half ^ (half >> TAG_SHIFT);
    assign set_idx = folded[SET_W-1:0];
endmodule

// File: rtl/stride_pf_table.sv
module stride_pf_table
    import stride_pf_pkg::*;
#(
    parameter int PC_W     = 16,
    parameter int LINE_W   = 20,
    parameter int SETS     = 4,
    parameter int WAYS     = 2,
    parameter int CONF_MAX = 3,
    localparam int SET_W   = $clog2(SETS),
    localparam int CONF_W  = $clog2(CONF_MAX + 1),
    localparam int AGE_W   = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PC_W-1:0]   lk_pc,
    input  logic [SET_W-1:0]  lk_set,
    input  logic [LINE_W-1:0] lk_line,
    input  logic              wr_en,
    output logic              hit,
    output logic [LINE_W-1:0] seen_stride,
    output logic [CONF_W-1:0] upd_conf
);
    typedef struct packed {
        logic              valid;
        logic [PC_W-1:0]   tag;
        logic [LINE_W-1:0] last;
        logic [LINE_W-1:0] stride;
        logic [CONF_W-1:0] conf;
        logic [AGE_W-1:0]  age;
    } entry_t;

    entry_t tbl [SETS][WAYS];

    logic [WAYS-1:0]   hit_vec;
    logic [AGE_W-1:0]  hit_way;
    logic [AGE_W-1:0]  vic_way;
    logic [AGE_W-1:0]  sel_way;
    logic              have_empty;
    entry_t            cur;
    logic              confirmed;
    logic [LINE_W-1:0] upd_stride;

    always_comb begin
        hit_vec    = '0;
        hit_way    = '0;
        vic_way    = '0;
        have_empty = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            hit_vec[w] = tbl[lk_set][w].valid && (tbl[lk_set][w].tag == lk_pc);
            if (hit_vec[w])
                hit_way = AGE_W'(w);
        end
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!tbl[lk_set][w].valid) begin
                vic_way    = AGE_W'(w);
                have_empty = 1'b1;
            end
        end
        if (!have_empty) begin
            for (int w = 0; w < WAYS; w++) begin
                if (tbl[lk_set][w].age == AGE_W'(WAYS - 1))
                    vic_way = AGE_W'(w);
            end
        end
    end

    assign hit     = |hit_vec;
    assign sel_way = hit ? hit_way : vic_way;
    assign cur     = tbl[lk_set][hit_way];

    assign seen_stride = lk_line - cur.last;
    assign confirmed   = (seen_stride == cur.stride) && (seen_stride != '0);
    assign upd_conf    = CONF_W'(conf_next(int'(cur.conf), confirmed, CONF_MAX));
    assign upd_stride  = (!confirmed && cur.conf == '0) ? seen_stride : cur.stride;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    tbl[s][w]     <= '0;
                    tbl[s][w].age <= AGE_W'(w);
                end
            end
        end else if (wr_en) begin
            tbl[lk_set][sel_way].valid <= 1'b1;
            tbl[lk_set][sel_way].tag   <= lk_pc;
            tbl[lk_set][sel_way].last  <= lk_line;
            if (hit) begin
                tbl[lk_set][sel_way].stride <= upd_stride;
                tbl[lk_set][sel_way].conf   <= upd_conf;
            end else begin
                tbl[lk_set][sel_way].stride <= '0;
                tbl[lk_set][sel_way].conf   <= '0;
            end
            for (int w = 0; w < WAYS; w++) begin
                if (AGE_W'(w) == sel_way)
                    tbl[lk_set][w].age <= '0;
                else if (tbl[lk_set][w].age < tbl[lk_set][sel_way].age)
                    tbl[lk_set][w].age <= tbl[lk_set][w].age + 1'b1;
            end
        end
    end

    // R1 / R8: a full-PC tag can match at most one way of a set.
    always_ff @(posedge clk) begin
        if (!rst) begin
            a_r8_single_hit: assert ($onehot0(hit_vec))
                else $error("a_r8_single_hit: several ways match one PC");
        end
    end

    // R3: no stored confidence ever exceeds the threshold.
    always_ff @(posedge clk) begin
        if (!rst) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    a_r3_conf_cap: assert (int'(tbl[s][w].conf) <= CONF_MAX)
                        else $error("a_r3_conf_cap: confidence above cap");
                end
            end
        end
    end
endmodule

// File: rtl/stride_pf_issue.sv
module stride_pf_issue
    import stride_pf_pkg::*;
#(
    parameter int LINE_W     = 20,
    parameter int DEG_W      = 3,
    parameter int BLK_SHIFT  = 6,
    parameter int PAGE_SHIFT = 12,
    localparam int PGL       = PAGE_SHIFT - BLK_SHIFT,
    localparam int ADDR_W    = LINE_W + BLK_SHIFT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [LINE_W-1:0] go_line,
    input  logic [LINE_W-1:0] go_stride,
    input  logic [DEG_W-1:0]  go_deg,
    output logic              busy,
    output logic              pf_valid,
    input  logic              pf_ready,
    output logic [ADDR_W-1:0] pf_addr
);
    pf_state_e             state;
    logic [LINE_W-1:0]     cand;
    logic [LINE_W-1:0]     step;
    logic [LINE_W-PGL-1:0] home;
    logic [DEG_W-1:0]      left;
    logic                  in_page;
    logic                  advance;

    assign in_page  = cand[LINE_W-1:PGL] == home;
    assign busy     = (state == PF_RUN);
    assign pf_valid = busy && in_page;
    assign pf_addr  = {cand, {BLK_SHIFT{1'b0}}};
    assign advance  = busy && (!in_page || pf_ready);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PF_IDLE;
            cand  <= '0;
            step  <= '0;
            home  <= '0;
            left  <= '0;
        end else if (go && !busy) begin
            cand  <= go_line + go_stride;
            step  <= go_stride;
            home  <= go_line[LINE_W-1:PGL];
            left  <= go_deg;
            state <= (go_deg != '0) ? PF_RUN : PF_IDLE;
        end else if (advance) begin
            cand <= cand + step;
            left <= left - 1'b1;
            if (left == DEG_W'(1))
                state <= PF_IDLE;
        end
    end

    // R11: an offered address is held until taken.
    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_addr)))
        else $error("a_r11_hold: offered address changed before acceptance");

    // R9: a running burst always has candidates left to handle.
    a_r9_left_nonzero: assert property (@(posedge clk) disable iff (rst)
        busy |-> (left != '0))
        else $error("a_r9_left_nonzero: burst running with nothing left");
endmodule

// File: rtl/stride_pf.sv
module stride_pf
    import stride_pf_pkg::*;
#(
    parameter int PC_W       = 16,
    parameter int LINE_W     = 20,
    parameter int SETS       = 4,
    parameter int WAYS       = 2,
    parameter int TAG_SHIFT  = 4,
    parameter int CONF_MAX   = 3,
    parameter int DEG_W      = 3,
    parameter int BLK_SHIFT  = 6,
    parameter int PAGE_SHIFT = 12,
    localparam int SET_W     = $clog2(SETS),
    localparam int CONF_W    = $clog2(CONF_MAX + 1),
    localparam int PGL       = PAGE_SHIFT - BLK_SHIFT,
    localparam int ADDR_W    = LINE_W + BLK_SHIFT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    output logic              acc_ready,
    input  logic [PC_W-1:0]   acc_pc,
    input  logic [LINE_W-1:0] acc_line,
    input  logic [DEG_W-1:0]  degree,
    output logic              pf_valid,
    input  logic              pf_ready,
    output logic [ADDR_W-1:0] pf_addr
);
    logic [SET_W-1:0]      set_idx;
    logic                  fire;
    logic                  hit;
    logic [LINE_W-1:0]     seen_stride;
    logic [CONF_W-1:0]     upd_conf;
    logic                  go;
    logic                  busy;
    logic [LINE_W-PGL-1:0] trig_page;

    stride_pf_hash #(
        .PC_W      (PC_W),
        .SET_W     (SET_W),
        .TAG_SHIFT (TAG_SHIFT)
    ) u_hash (
        .pc      (acc_pc),
        .set_idx (set_idx)
    );

    stride_pf_table #(
        .PC_W     (PC_W),
        .LINE_W   (LINE_W),
        .SETS     (SETS),
        .WAYS     (WAYS),
        .CONF_MAX (CONF_MAX)
    ) u_table (
        .clk         (clk),
        .rst         (rst),
        .lk_pc       (acc_pc),
        .lk_set      (set_idx),
        .lk_line     (acc_line),
        .wr_en       (fire),
        .hit         (hit),
        .seen_stride (seen_stride),
        .upd_conf    (upd_conf)
    );

    assign acc_ready = !busy;
    assign fire      = acc_valid && acc_ready;
    assign go        = fire && hit && (upd_conf == CONF_W'(CONF_MAX));

    stride_pf_issue #(
        .LINE_W     (LINE_W),
        .DEG_W      (DEG_W),
        .BLK_SHIFT  (BLK_SHIFT),
        .PAGE_SHIFT (PAGE_SHIFT)
    ) u_issue (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .go_line   (acc_line),
        .go_stride (seen_stride),
        .go_deg    (degree),
        .busy      (busy),
        .pf_valid  (pf_valid),
        .pf_ready  (pf_ready),
        .pf_addr   (pf_addr)
    );

    always_ff @(posedge clk) begin
        if (rst)
            trig_page <= '0;
        else if (fire)
            trig_page <= acc_line[LINE_W-1:PGL];
    end

    // R7: every offered address lies in the page of its triggering access.
    a_r7_same_page: assert property (@(posedge clk) disable iff (rst)
        pf_valid |-> (pf_addr[ADDR_W-1:PAGE_SHIFT] == trig_page))
        else $error("a_r7_same_page: prefetch left the trigger page");

    // R9: the access port is closed whenever a prefetch is offered.
    a_r9_port_closed: assert property (@(posedge clk) disable iff (rst)
        pf_valid |-> !acc_ready)
        else $error("a_r9_port_closed: access port open during a burst");

    // R10: leaving reset, nothing is offered and the port is open.
    a_r10_reset_state: assert property (@(posedge clk)
        rst |=> (!pf_valid && acc_ready))
        else $error("a_r10_reset_state: wrong state after reset");
endmodule

// File: tb/stride_pf_test.sv
module stride_pf_test;
    localparam int PC_W       = 16;
    localparam int LINE_W     = 20;
    localparam int SETS       = 4;
    localparam int WAYS       = 2;
    localparam int TAG_SHIFT  = 4;
    localparam int CONF_MAX   = 3;
    localparam int DEG_W      = 3;
    localparam int BLK_SHIFT  = 6;
    localparam int PAGE_SHIFT = 12;
    localparam int PGL        = PAGE_SHIFT - BLK_SHIFT;
    localparam int ADDR_W     = LINE_W + BLK_SHIFT;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              acc_valid = 1'b0;
    logic              acc_ready;
    logic [PC_W-1:0]   acc_pc = '0;
    logic [LINE_W-1:0] acc_line = '0;
    logic [DEG_W-1:0]  degree = '0;
    logic              pf_valid;
    logic              pf_ready = 1'b1;
    logic [ADDR_W-1:0] pf_addr;

    stride_pf #(
        .PC_W(PC_W), .LINE_W(LINE_W), .SETS(SETS), .WAYS(WAYS),
        .TAG_SHIFT(TAG_SHIFT), .CONF_MAX(CONF_MAX), .DEG_W(DEG_W),
        .BLK_SHIFT(BLK_SHIFT), .PAGE_SHIFT(PAGE_SHIFT)
    ) uut (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_ready(acc_ready),
        .acc_pc(acc_pc), .acc_line(acc_line), .degree(degree),
        .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr)
    );

    always #10 clk = ~clk;   // 50 MHz

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    int unsigned seed = 32'h1234_5678;

    // Reference model state
    logic              m_v    [SETS][WAYS];
    logic [PC_W-1:0]   m_tag  [SETS][WAYS];
    logic [LINE_W-1:0] m_last [SETS][WAYS];
    logic [LINE_W-1:0] m_str  [SETS][WAYS];
    int                m_conf [SETS][WAYS];
    int                m_age  [SETS][WAYS];

    logic [ADDR_W-1:0] exp_a [8];
    int                exp_n;
    bit                exp_go;
    int                exp_deg;
    bit                exp_drop;
    bit                exp_hit;

    function automatic int unsigned rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed >> 8;
    endfunction

    function automatic int set_of(logic [PC_W-1:0] pc);
        logic [PC_W-1:0] h;
        h = pc >> 1;
        return int'((h ^ (h >> TAG_SHIFT)) % SETS);
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                m_v[s][w] = 1'b0; m_tag[s][w] = '0; m_last[s][w] = '0;
                m_str[s][w] = '0; m_conf[s][w] = 0; m_age[s][w] = w;
            end
    endtask

    task automatic model_touch(int s, int w);
        int old;
        old = m_age[s][w];
        for (int v = 0; v < WAYS; v++)
            if (m_age[s][v] < old) m_age[s][v]++;
        m_age[s][w] = 0;
    endtask

    task automatic model_step(logic [PC_W-1:0] pc, logic [LINE_W-1:0] line, int deg);
        int s, w;
        logic [LINE_W-1:0] ns, c;
        bit match;
        s = set_of(pc);
        w = -1;
        exp_n = 0; exp_go = 1'b0; exp_drop = 1'b0; exp_deg = deg;
        for (int v = 0; v < WAYS; v++)
            if (m_v[s][v] && m_tag[s][v] == pc) w = v;
        exp_hit = (w >= 0);
        if (w >= 0) begin
            ns = line - m_last[s][w];
            match = (ns == m_str[s][w]) && (ns != '0);
            if (match) begin
                if (m_conf[s][w] < CONF_MAX) m_conf[s][w]++;
            end else if (m_conf[s][w] == 0) begin
                m_str[s][w] = ns;
            end else begin
                m_conf[s][w]--;
            end
            m_last[s][w] = line;
            model_touch(s, w);
            if (m_conf[s][w] >= CONF_MAX && deg > 0) begin
                exp_go = 1'b1;
                c = line;
                for (int d = 1; d <= deg; d++) begin
                    c = c + ns;
                    if (c[LINE_W-1:PGL] == line[LINE_W-1:PGL]) begin
                        exp_a[exp_n] = {c, {BLK_SHIFT{1'b0}}};
                        exp_n++;
                    end else begin
                        exp_drop = 1'b1;
                    end
                end
            end
        end else begin
            w = -1;
            for (int v = WAYS - 1; v >= 0; v--)
                if (!m_v[s][v]) w = v;
            if (w < 0)
                for (int v = 0; v < WAYS; v++)
                    if (m_age[s][v] == WAYS - 1) w = v;
            m_v[s][w] = 1'b1; m_tag[s][w] = pc; m_last[s][w] = line;
            m_str[s][w] = '0; m_conf[s][w] = 0;
            model_touch(s, w);
        end
    endtask

    // One access; tag names the requirement the burst length check targets.
    task automatic access(logic [PC_W-1:0] pc, logic [LINE_W-1:0] line, int deg,
                          bit stall, string tag);
        logic [ADDR_W-1:0] got [16];
        int got_n, busy_n, stall_n;
        bit held;
        logic [ADDR_W-1:0] held_addr;
        string ctag;
        acc_pc = pc; acc_line = line; degree = DEG_W'(deg); acc_valid = 1'b1;
        @(posedge clk);
        model_step(pc, line, deg);
        got_n = 0; busy_n = 0; stall_n = 0; held = 1'b0; held_addr = '0;
        @(negedge clk);
        acc_valid = 1'b0;
        forever begin
            pf_ready = stall ? rnd() % 3 != 0 : 1'b1;
            #1;
            if (held)
                check(pf_valid && pf_addr == held_addr, "R11", "held address",
                      longint'(pf_addr), longint'(held_addr));
            held = 1'b0;
            if (acc_ready) break;
            busy_n++;
            if (pf_valid && pf_ready && got_n < 16) begin
                got[got_n] = pf_addr; got_n++;
            end
            if (pf_valid && !pf_ready) begin
                stall_n++; held = 1'b1; held_addr = pf_addr;
            end
            if (busy_n > 40) break;
            @(negedge clk);
        end
        if (!exp_hit) ctag = "R8";
        else if (!exp_go) ctag = "R5";
        else if (exp_drop) ctag = "R7";
        else ctag = tag;
        check(got_n == exp_n, ctag, "prefetch count", got_n, exp_n);
        for (int i = 0; i < exp_n && i < got_n; i++)
            check(got[i] == exp_a[i], exp_drop ? "R7" : "R6", "prefetch address",
                  longint'(got[i]), longint'(exp_a[i]));
        check(busy_n == (exp_go ? exp_deg + stall_n : 0), "R9", "busy cycles",
              busy_n, exp_go ? exp_deg + stall_n : 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int strides [8] = '{1, 3, -2, 7, 0, -1, 20, -33};
        logic [PC_W-1:0] same [3];
        int ns;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(acc_ready == 1'b1, "R10", "acc_ready after reset", acc_ready, 1);
        check(pf_valid == 1'b0, "R10", "pf_valid after reset", pf_valid, 0);

        // R3 / R6 / R7: steady strides, all degrees
        for (int si = 0; si < 8; si++) begin
            for (int k = 0; k < 8; k++)
                access(PC_W'(16'h0400 + si * 4),
                       LINE_W'(32'h1000 + si * 32'h300 + k * strides[si]),
                       (k + si) % 6, 1'b0, "R3");
        end

        // R4: trained stride broken, decayed, then replaced
        for (int k = 0; k < 6; k++)
            access(16'h0520, LINE_W'(32'h8000 + k * 4), 4, 1'b0, "R4");
        access(16'h0520, LINE_W'(32'h8030), 4, 1'b0, "R4");
        access(16'h0520, LINE_W'(32'h8031), 4, 1'b0, "R4");
        access(16'h0520, LINE_W'(32'h8041), 4, 1'b0, "R4");
        for (int k = 1; k < 7; k++)
            access(16'h0520, LINE_W'(32'h8041 + k * 2), 3, 1'b0, "R4");

        // R1: two PCs with one set, differing only in the top bit
        for (int k = 0; k < 6; k++)
            access(16'h0010, LINE_W'(32'h2000 + k), 2, 1'b0, "R1");
        access(16'h8010, LINE_W'(32'h2006), 2, 1'b0, "R1");
        access(16'h0010, LINE_W'(32'h2006), 2, 1'b0, "R1");
        access(16'h8010, LINE_W'(32'h2008), 2, 1'b0, "R1");

        // R8: three PCs in one set force LRU eviction
        same[0] = 16'h2000; ns = 1;
        for (int p = 16'h2002; p < 16'h3000 && ns < 3; p += 2)
            if (set_of(PC_W'(p)) == set_of(same[0])) begin
                same[ns] = PC_W'(p); ns++;
            end
        for (int r = 0; r < 6; r++) begin
            access(same[0], LINE_W'(32'h3000 + r * 2), 2, 1'b0, "R8");
            access(same[1], LINE_W'(32'h4000 + r * 3), 2, 1'b0, "R8");
            if (r % 2 == 1)
                access(same[2], LINE_W'(32'h5000 + r), 2, 1'b0, "R8");
        end

        // R2 / R11: mixed PCs, noisy strides, stalling consumer
        for (int n = 0; n < 400; n++) begin
            int p;
            p = int'(rnd() % 6);
            access(PC_W'(16'h0600 + p * 6),
                   LINE_W'(32'h9000 + p * 32'h1000 + (n / 6) * (p + 1) +
                           ((rnd() % 7 == 0) ? 5 : 0)),
                   int'(rnd() % 6), 1'b1, "R2");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule